// File: doc/BRIEF.md
# Cross-Domain Register Access Bridge

This block lets a processor in a fast clock domain read and write a 32-bit register space that lives in a slower, separately clocked and separately reset domain, such as an always-on timekeeping island. On the processor side, four word-sized staging registers sit behind a small register port: a control word, an operation word, a remote address and a data word. Software stages an access in the operation, address and data registers and then sets bit 0 of the control word.

When an access starts, the bridge copies the staged operation, address and data into hold registers and flips a request toggle. That toggle crosses into the slow domain through a synchroniser chain. There the bridge issues exactly one single-cycle read or write strobe on a plain register port and flips an acknowledge toggle, which returns through a matching chain. Read data is captured in the slow domain at the strobe and held there. The processor side loads it into the data register on the same edge where busy drops. Until that edge, the control word reads as busy, and starts and staging writes are ignored.

Top module: `xdom_reg_bridge`

## Requirements
- R1: After both resets, the control register (word 0) reads zero, and neither far-side strobe is asserted during or after reset until a transaction is started.
- R2: A host write to word 0 with bit 0 set while idle starts one transaction, and word 0 reads 1 from the next host cycle until completion. A write to word 0 with bit 0 clear starts nothing.
- R3: With the operation register (word 1) at 0x00, a transaction issues exactly one single-cycle `s_rd_stb` at the staged address. Once idle, word 3 holds the value that the far side returned.
- R4: With word 1 at 0xF1, a transaction issues exactly one single-cycle `s_wr_stb` carrying the staged address, `s_wdata` equal to word 3, and `s_be` = 4'hF. The two strobes are never asserted together.
- R5: Bit 0 of word 1 selects a write (1) or a read (0). Bits [7:4] of word 1 drive `s_be[3:0]`, where `s_be[i]` enables byte i, so 0x31 writes only the two low bytes.
- R6: A start written while a transaction is in flight is ignored, so the far side sees exactly one strobe per accepted start.
- R7: Writes to words 1, 2 and 3 while busy are ignored. Once the bridge is idle again, the registers read back their earlier values, and the in-flight access used those earlier values.
- R8: Busy clears only after the far-side acknowledge has returned through the synchroniser, so when busy reads zero, the far-side strobe has already occurred.
- R9: While idle, words 1, 2 and 3 read back the last values written to them. Word 1 reads back as 8 bits, zero-extended.
- R10: The hold registers that feed the far-side address, data, enables and direction stay unchanged for as long as a transaction is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_h | input | 1 | Processor-side clock |
| rst_h_n | input | 1 | Processor-side asynchronous active-low reset |
| h_sel | input | 1 | Register port access strobe |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_word | input | 2 | Register select: 0 control, 1 operation, 2 address, 3 data |
| h_wdata | input | 32 | Write data |
| h_rdata | output | 32 | Read data for the selected register (combinational) |
| clk_s | input | 1 | Far-side clock |
| rst_s_n | input | 1 | Far-side asynchronous active-low reset |
| s_rd_stb | output | 1 | Single-cycle far-side read strobe |
| s_wr_stb | output | 1 | Single-cycle far-side write strobe |
| s_addr | output | ADDR_W | Far-side register address |
| s_be | output | 4 | Far-side byte enables |
| s_wdata | output | 32 | Far-side write data |
| s_rdata | input | 32 | Far-side read data, sampled on the read strobe |

## Verification
The bench builds the bridge with its defaults: a two-stage synchroniser and a 32-bit remote address. The slow clock runs at a non-integer ratio of about 7.4 host cycles per slow cycle, so the toggles arrive at varying phases. Because each transaction then lasts tens of host cycles, the bench has room to issue a second start and to write the staging registers mid-flight, and it can confirm that the in-flight access used the earlier values. A behavioural remote memory with byte-masked writes serves as the reference. Its strobe counts expose any lost or duplicated request.

// File: rtl/xb_pkg.sv
package xb_pkg;
  localparam int DATA_W    = 32;
  localparam int OP_W      = 8;
  localparam int BE_W      = DATA_W / 8;
  localparam int WFLAG_BIT = 0;
  localparam int BE_LSB    = 4;

  typedef enum logic [1:0] {
    W_CTRL = 2'd0,
    W_OP   = 2'd1,
    W_ADDR = 2'd2,
    W_DATA = 2'd3
  } word_sel_e;
endpackage

// File: rtl/xb_sync.sv
module xb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xb_host.sv
module xb_host
  import xb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_sel_i,
  input  logic              h_wr_i,
  input  logic [1:0]        h_word_i,
  input  logic [DATA_W-1:0] h_wdata_i,
  output logic [DATA_W-1:0] h_rdata_o,
  output logic              req_tgl_o,
  output logic [ADDR_W-1:0] hold_addr_o,
  output logic [DATA_W-1:0] hold_data_o,
  output logic              hold_wr_o,
  output logic [BE_W-1:0]   hold_be_o,
  input  logic              ack_tgl_i,
  input  logic [DATA_W-1:0] rdat_i
);
  logic              busy_q, busy_d;
  logic              req_q, req_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [ADDR_W-1:0] haddr_q, haddr_d;
  logic [DATA_W-1:0] hdata_q, hdata_d;
  logic [OP_W-1:0]   hop_q, hop_d;
  logic              ack_sync;
  logic              wr_go, start, stage_ok, done;

  xb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_tgl_i), .q(ack_sync)
  );

  assign wr_go    = h_sel_i & h_wr_i;
  assign stage_ok = wr_go & ~busy_q;
  assign start    = stage_ok & (h_word_i == W_CTRL) & h_wdata_i[0];
  assign done     = busy_q & (ack_sync == req_q);

  always_comb begin
    busy_d  = busy_q;
    req_d   = req_q;
    op_d    = op_q;
    addr_d  = addr_q;
    data_d  = data_q;
    haddr_d = haddr_q;
    hdata_d = hdata_q;
    hop_d   = hop_q;
    if (start) begin
      busy_d  = 1'b1;
      req_d   = ~req_q;
      haddr_d = addr_q;
      hdata_d = data_q;
      hop_d   = op_q;
    end else if (done) begin
      busy_d = 1'b0;
      if (!hop_q[WFLAG_BIT]) data_d = rdat_i;
    end
    if (stage_ok) begin
      case (h_word_i)
        W_OP:    op_d   = h_wdata_i[OP_W-1:0];
        W_ADDR:  addr_d = h_wdata_i[ADDR_W-1:0];
        W_DATA:  data_d = h_wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      req_q   <= 1'b0;
      op_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      haddr_q <= '0;
      hdata_q <= '0;
      hop_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      req_q   <= req_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      haddr_q <= haddr_d;
      hdata_q <= hdata_d;
      hop_q   <= hop_d;
    end
  end

  always_comb begin
    case (h_word_i)
      W_CTRL:  h_rdata_o = {{(DATA_W-1){1'b0}}, busy_q};
      W_OP:    h_rdata_o = {{(DATA_W-OP_W){1'b0}}, op_q};
      W_ADDR:  h_rdata_o = DATA_W'(addr_q);
      default: h_rdata_o = data_q;
    endcase
  end

  assign req_tgl_o   = req_q;
  assign hold_addr_o = haddr_q;
  assign hold_data_o = hdata_q;
  assign hold_wr_o   = hop_q[WFLAG_BIT];
  assign hold_be_o   = hop_q[BE_LSB +: BE_W];

  // R7: staging frozen while busy
  a_r7_stage_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(addr_q) && $stable(op_q)));
  // R10: hold registers stable while a request is outstanding
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(haddr_q) && $stable(hdata_q) && $stable(hop_q)));
  // R6: no second request toggle while busy
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(req_q));
  // R8: busy holds until the acknowledge matches the request
  a_r8_busy_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (ack_sync != req_q)) |=> busy_q);
endmodule

// File: rtl/xb_far.sv
module xb_far
  import xb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgl_i,
  input  logic [ADDR_W-1:0] hold_addr_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic              hold_wr_i,
  input  logic [BE_W-1:0]   hold_be_i,
  output logic              rd_stb_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BE_W-1:0]   be_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              ack_tgl_o,
  output logic [DATA_W-1:0] rdat_o
);
  logic              req_sync;
  logic              ack_q, ack_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              fire;

  xb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_tgl_i), .q(req_sync)
  );

  assign fire = req_sync ^ ack_q;

  always_comb begin
    ack_d  = ack_q;
    rdat_d = rdat_q;
    if (fire) begin
      ack_d = req_sync;
      if (!hold_wr_i) rdat_d = rdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      ack_q  <= ack_d;
      rdat_q <= rdat_d;
    end
  end

  assign rd_stb_o  = fire & ~hold_wr_i;
  assign wr_stb_o  = fire & hold_wr_i;
  assign addr_o    = hold_addr_i;
  assign be_o      = hold_be_i;
  assign wdata_o   = hold_data_i;
  assign ack_tgl_o = ack_q;
  assign rdat_o    = rdat_q;

  // R4: read and write strobes exclusive
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_stb_o, wr_stb_o}));
  // R3: each strobe lasts one far-side cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_o || wr_stb_o) |=> !(rd_stb_o || wr_stb_o));
endmodule

// File: rtl/xdom_reg_bridge.sv
module xdom_reg_bridge
  import xb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_h,
  input  logic              rst_h_n,
  input  logic              h_sel,
  input  logic              h_wr,
  input  logic [1:0]        h_word,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  input  logic              clk_s,
  input  logic              rst_s_n,
  output logic              s_rd_stb,
  output logic              s_wr_stb,
  output logic [ADDR_W-1:0] s_addr,
  output logic [3:0]        s_be,
  output logic [31:0]       s_wdata,
  input  logic [31:0]       s_rdata
);
  logic              rst_h_q, rst_s_q;
  logic              req_tgl, ack_tgl;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data, rdat;
  logic              hold_wr;
  logic [BE_W-1:0]   hold_be;

  xb_sync #(.STAGES(2)) u_rst_h (
    .clk(clk_h), .rst_n(rst_h_n), .d(1'b1), .q(rst_h_q)
  );
  xb_sync #(.STAGES(2)) u_rst_s (
    .clk(clk_s), .rst_n(rst_s_n), .d(1'b1), .q(rst_s_q)
  );

  xb_host #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_host (
    .clk(clk_h), .rst_n(rst_h_q),
    .h_sel_i(h_sel), .h_wr_i(h_wr), .h_word_i(h_word),
    .h_wdata_i(h_wdata), .h_rdata_o(h_rdata),
    .req_tgl_o(req_tgl), .hold_addr_o(hold_addr), .hold_data_o(hold_data),
    .hold_wr_o(hold_wr), .hold_be_o(hold_be),
    .ack_tgl_i(ack_tgl), .rdat_i(rdat)
  );

  xb_far #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_far (
    .clk(clk_s), .rst_n(rst_s_q),
    .req_tgl_i(req_tgl), .hold_addr_i(hold_addr), .hold_data_i(hold_data),
    .hold_wr_i(hold_wr), .hold_be_i(hold_be),
    .rd_stb_o(s_rd_stb), .wr_stb_o(s_wr_stb), .addr_o(s_addr),
    .be_o(s_be), .wdata_o(s_wdata), .rdata_i(s_rdata),
    .ack_tgl_o(ack_tgl), .rdat_o(rdat)
  );

  // R1: no strobes while the far side is held in reset
  always @(posedge clk_s) begin
    if (!rst_s_q) a_r1_quiet_reset: assert (!s_rd_stb && !s_wr_stb);
  end
endmodule

// File: tb/xdom_reg_bridge_bench.sv
`timescale 1ns/100ps
module xdom_reg_bridge_bench;
  logic clk_h = 1'b0, clk_s = 1'b0;
  logic rst_h_n = 1'b0, rst_s_n = 1'b0;
  logic h_sel = 1'b0, h_wr = 1'b0;
  logic [1:0] h_word = 2'd0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic s_rd_stb, s_wr_stb;
  logic [31:0] s_addr, s_wdata, s_rdata;
  logic [3:0] s_be;

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] mem [16];
  logic [31:0] exp_mem [16];

  always #2.5 clk_h = ~clk_h;
  always #18.5 clk_s = ~clk_s;

  xdom_reg_bridge u_xdom_reg_bridge (
    .clk_h(clk_h), .rst_h_n(rst_h_n), .h_sel(h_sel), .h_wr(h_wr),
    .h_word(h_word), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .clk_s(clk_s), .rst_s_n(rst_s_n), .s_rd_stb(s_rd_stb),
    .s_wr_stb(s_wr_stb), .s_addr(s_addr), .s_be(s_be),
    .s_wdata(s_wdata), .s_rdata(s_rdata)
  );

  // behavioural far-side register space
  assign s_rdata = mem[s_addr[5:2]];
  always @(posedge clk_s) begin
    if (s_rd_stb) rd_cnt <= rd_cnt + 1;
    if (s_wr_stb) begin
      wr_cnt <= wr_cnt + 1;
      for (int b = 0; b < 4; b++)
        if (s_be[b]) mem[s_addr[5:2]][8*b +: 8] <= s_wdata[8*b +: 8];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] w, input logic [31:0] v);
    @(negedge clk_h);
    h_sel = 1'b1; h_wr = 1'b1; h_word = w; h_wdata = v;
    @(negedge clk_h);
    h_sel = 1'b0; h_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] w, output logic [31:0] v);
    @(negedge clk_h);
    h_sel = 1'b1; h_wr = 1'b0; h_word = w;
    #0.5 v = h_rdata;
    h_sel = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    int n = 0;
    do begin
      hread(2'd0, v);
      n++;
    end while (v != 0 && n < 400);
    chk(n < 400, req, v, 32'd0);
  endtask

  // full transaction; returns data register afterwards
  task automatic xact(input logic [7:0] op, input logic [31:0] a,
                      input logic [31:0] d, output logic [31:0] res);
    logic [31:0] v;
    int r0, w0;
    wait_idle("R2");
    hwrite(2'd1, {24'd0, op});
    hwrite(2'd2, a);
    hwrite(2'd3, d);
    r0 = rd_cnt; w0 = wr_cnt;
    hwrite(2'd0, 32'd1);
    hread(2'd0, v);
    chk(v == 32'd1, "R2 busy after start", v, 32'd1);
    wait_idle("R8");
    chk(rd_cnt - r0 == (op[0] ? 0 : 1), "R3/R8 read strobe count", rd_cnt - r0,
        op[0] ? 0 : 1);
    chk(wr_cnt - w0 == (op[0] ? 1 : 0), "R4/R8 write strobe count", wr_cnt - w0,
        op[0] ? 1 : 0);
    hread(2'd3, res);
  endtask

  initial begin
    #500_000;
    checks++; errors++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, exp;
    int r0, w0;
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'hA500_0000 + i * 32'h0101_0101;
      exp_mem[i] = mem[i];
    end
    #100;
    chk(!s_rd_stb && !s_wr_stb, "R1 strobes in reset", {s_rd_stb, s_wr_stb}, 0);
    rst_h_n = 1'b1; rst_s_n = 1'b1;
    repeat (30) @(negedge clk_h);
    hread(2'd0, v);
    chk(v == 0, "R1 ctrl after reset", v, 0);
    chk(rd_cnt == 0 && wr_cnt == 0, "R1 no strobes", rd_cnt + wr_cnt, 0);

    // R9 readback
    hwrite(2'd1, 32'hFFFF_FF31);
    hread(2'd1, v);
    chk(v == 32'h31, "R9 op readback", v, 32'h31);
    hwrite(2'd2, 32'h0000_0024);
    hread(2'd2, v);
    chk(v == 32'h24, "R9 addr readback", v, 32'h24);

    // R2 bit0 clear: no start
    hwrite(2'd0, 32'd2);
    repeat (80) @(negedge clk_h);
    hread(2'd0, v);
    chk(v == 0, "R2 ctrl bit0 clear", v, 0);
    chk(rd_cnt == 0 && wr_cnt == 0, "R2 no transaction", rd_cnt + wr_cnt, 0);

    // R3 reads at several addresses
    for (int k = 0; k < 3; k++) begin
      xact(8'h00, 32'h4 * (k * 5 + 1), 32'h0, v);
      exp = exp_mem[k * 5 + 1];
      chk(v == exp, "R3 read data", v, exp);
    end

    // R4 full writes, checked by read-back through the bridge
    xact(8'hF1, 32'h08, 32'hDEAD_BEEF, v);
    exp_mem[2] = 32'hDEAD_BEEF;
    chk(v == 32'hDEAD_BEEF, "R4 data reg unchanged by write", v, 32'hDEAD_BEEF);
    chk(mem[2] == exp_mem[2], "R4 remote full write", mem[2], exp_mem[2]);
    xact(8'hF1, 32'h3C, 32'h1234_5678, v);
    exp_mem[15] = 32'h1234_5678;
    xact(8'h00, 32'h3C, 32'h0, v);
    chk(v == exp_mem[15], "R4 write then read", v, exp_mem[15]);

    // R5 partial write, low two bytes
    xact(8'h31, 32'h10, 32'h7766_5544, v);
    exp_mem[4] = {exp_mem[4][31:16], 16'h5544};
    xact(8'h00, 32'h10, 32'h0, v);
    chk(v == exp_mem[4], "R5 low-byte write", v, exp_mem[4]);
    // R5 byte enables for byte 3 only
    xact(8'h81, 32'h14, 32'hC3C2_C1C0, v);
    exp_mem[5] = {8'hC3, exp_mem[5][23:0]};
    chk(mem[5] == exp_mem[5], "R5 top-byte write", mem[5], exp_mem[5]);

    // R6/R7 restart and staging writes while busy
    wait_idle("R6");
    hwrite(2'd1, 32'h00);
    hwrite(2'd2, 32'h18);
    r0 = rd_cnt; w0 = wr_cnt;
    hwrite(2'd0, 32'd1);
    hwrite(2'd1, 32'hF1);
    hwrite(2'd2, 32'h1C);
    hwrite(2'd3, 32'h5555_AAAA);
    hwrite(2'd0, 32'd1);
    wait_idle("R6");
    repeat (120) @(negedge clk_h);
    chk(rd_cnt - r0 == 1, "R6 one read strobe", rd_cnt - r0, 1);
    chk(wr_cnt - w0 == 0, "R6 no write strobe", wr_cnt - w0, 0);
    hread(2'd1, v);
    chk(v == 0, "R7 op unchanged", v, 0);
    hread(2'd2, v);
    chk(v == 32'h18, "R7 addr unchanged", v, 32'h18);
    hread(2'd3, v);
    chk(v == exp_mem[6], "R7 data from old addr", v, exp_mem[6]);
    chk(mem[7] == exp_mem[7], "R7 no remote write", mem[7], exp_mem[7]);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule